// File: doc/BRIEF.md
# SD card initialisation sequencer

This block takes an SD card from power-up to the ready state without processor help. It drives a command path engine through a request/completion handshake: one command at a time goes out with its index, argument and whether a response is expected, and the engine reports back a completion status and the 32-bit response word.

After a start pulse the sequencer sends a reset command and then probes the card's interface condition. The card counts as high capacity only if it echoes the voltage/check pattern. The sequencer then loops over an application-command prefix followed by the operating-condition command. The operating-condition argument depends on the card class. The loop ends when the card reports power-up complete. Between loop passes it leaves the command path idle for a programmable number of cycles. A pass limit turns a card that never becomes ready into an error.

Top module: `sd_init_seq`

## Requirements
- R1: After reset, done_o, err_o, hc_o and cmd_req_o are low.
- R2: A start_i pulse in idle, done or error state issues index 0 with argument 0 and cmd_resp_exp_o low. The completion code on cmd_status_i is 2'b00 sent, 2'b01 response received, 2'b10 timeout, 2'b11 fault. Any code other than sent ends the sequence with err_o high. While a sequence runs, start_i is ignored.
- R3: The second command is index 8, argument 0x000001AA, with a response expected.
- R4: hc_o goes high only if index 8 completes with code response and cmd_resp_i[11:0] equals 0x1AA. A timeout, fault or mismatched echo leaves hc_o low, and the sequence continues without error.
- R5: Each loop pass starts with index 55, argument 0, response expected. A code other than response, or cmd_resp_i[5] low, gives err_o.
- R6: Index 41 follows index 55 with argument 0x40FF8000 when hc_o is high and 0x00800000 otherwise. A code other than response gives err_o.
- R7: Passes repeat until an index 41 response has bit 31 set. Then done_o rises, hc_o holds the card class, and no further request is made until the next start.
- R8: Between a not-ready index 41 completion and the next index 55 request, cmd_req_o stays low for exactly delay_i cycles.
- R9: If pass number p (counted from 1) ends not ready and p >= retry_max_i, err_o is raised instead of another pass. A limit of 0 behaves like 1.
- R10: Once raised, cmd_req_o stays high with stable index and argument until the cycle cmd_done_i is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an initialisation sequence |
| delay_i | input | DLY_W | Idle cycles between loop passes |
| retry_max_i | input | RETRY_W | Maximum loop passes |
| cmd_req_o | output | 1 | Command request to the engine |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_resp_exp_o | output | 1 | A short response is expected |
| cmd_done_i | input | 1 | One-cycle completion from the engine |
| cmd_status_i | input | 2 | Completion code |
| cmd_resp_i | input | 32 | Response word, valid with cmd_done_i |
| done_o | output | 1 | Card ready |
| err_o | output | 1 | Sequence failed |
| hc_o | output | 1 | Card is high capacity |

## Verification
Directed runs cover a card that echoes the pattern, one that times out on the probe, and one that returns a wrong echo. These separate the high-capacity and standard branches by the operating-condition argument that follows. Fault injection at each step separates where the sequence stops: a failed reset, a missing or bit-5-clear application response, a missing operating-condition response, and a card that never becomes ready under both a normal and a zero pass limit. Randomised runs vary ready pass, pass limit, inter-pass delay and engine latency. They also chain sequences without reset, which shows that restart from the done and error states works.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD0, S_CMD8, S_APP, S_OP, S_WAIT, S_DONE, S_ERR
  } seq_st_e;

  typedef enum logic [1:0] {
    ST_SENT  = 2'b00,
    ST_RESP  = 2'b01,
    ST_TMO   = 2'b10,
    ST_FAULT = 2'b11
  } cmd_st_e;

  localparam logic [5:0]  IDX_RST  = 6'd0;
  localparam logic [5:0]  IDX_IFC  = 6'd8;
  localparam logic [5:0]  IDX_APP  = 6'd55;
  localparam logic [5:0]  IDX_OPC  = 6'd41;
  localparam logic [31:0] ARG_IFC  = 32'h0000_01AA;
  localparam logic [31:0] ARG_OPHC = 32'h40FF_8000;
  localparam logic [31:0] ARG_OPSC = 32'h0080_0000;
endpackage

// File: rtl/sd_init_dly.sv
module sd_init_dly #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  input  logic             en_i,
  output logic             zero_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R8: wait window shrinks by one per cycle
  assert_dly_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !zero_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sd_init_pass.sv
module sd_init_pass #(
  parameter int RETRY_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [RETRY_W-1:0] limit_i,
  output logic               at_limit_o
);
  logic [RETRY_W-1:0] cnt_q;
  logic [RETRY_W:0]   cur_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // pass currently ending, 1-based
  assign cur_pass   = {1'b0, cnt_q} + 1'b1;
  assign at_limit_o = (cur_pass >= {1'b0, limit_i});

  // R9: counter is stopped by the limit before it can wrap
  assert_pass_nowrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (cnt_q != '1));
endmodule

// File: rtl/sd_init_fsm.sv
module sd_init_fsm
  import sd_init_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        dly_cfg_zero_i,
  input  logic        dly_zero_i,
  input  logic        pass_limit_i,
  input  logic        cmd_done_i,
  input  logic [1:0]  cmd_status_i,
  input  logic [31:0] cmd_resp_i,
  output logic        cmd_req_o,
  output logic [5:0]  cmd_idx_o,
  output logic [31:0] cmd_arg_o,
  output logic        cmd_resp_exp_o,
  output logic        dly_load_o,
  output logic        dly_en_o,
  output logic        pass_clr_o,
  output logic        pass_inc_o,
  output logic        done_o,
  output logic        err_o,
  output logic        hc_o
);
  seq_st_e st_q, st_d;
  logic    hc_q, hc_d;
  cmd_st_e cst;
  logic    got_resp;

  assign cst      = cmd_st_e'(cmd_status_i);
  assign got_resp = (cst == ST_RESP);

  always_comb begin
    st_d       = st_q;
    hc_d       = hc_q;
    dly_load_o = 1'b0;
    pass_clr_o = 1'b0;
    pass_inc_o = 1'b0;
    unique case (st_q)
      S_IDLE, S_DONE, S_ERR: if (start_i) begin
        st_d = S_CMD0; hc_d = 1'b0; pass_clr_o = 1'b1;
      end
      S_CMD0: if (cmd_done_i) st_d = (cst == ST_SENT) ? S_CMD8 : S_ERR;
      S_CMD8: if (cmd_done_i) begin
        hc_d = got_resp && (cmd_resp_i[11:0] == ARG_IFC[11:0]);
        st_d = S_APP;
        pass_clr_o = 1'b1;
      end
      S_APP: if (cmd_done_i) st_d = (got_resp && cmd_resp_i[5]) ? S_OP : S_ERR;
      S_OP: if (cmd_done_i) begin
        if (!got_resp)          st_d = S_ERR;
        else if (cmd_resp_i[31]) st_d = S_DONE;
        else if (pass_limit_i)  st_d = S_ERR;
        else begin
          pass_inc_o = 1'b1;
          dly_load_o = !dly_cfg_zero_i;
          st_d       = dly_cfg_zero_i ? S_APP : S_WAIT;
        end
      end
      S_WAIT: if (dly_zero_i) st_d = S_APP;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      hc_q <= 1'b0;
    end else begin
      st_q <= st_d;
      hc_q <= hc_d;
    end
  end

  always_comb begin
    cmd_req_o      = 1'b1;
    cmd_resp_exp_o = 1'b1;
    cmd_idx_o      = IDX_RST;
    cmd_arg_o      = '0;
    unique case (st_q)
      S_CMD0: cmd_resp_exp_o = 1'b0;
      S_CMD8: begin cmd_idx_o = IDX_IFC; cmd_arg_o = ARG_IFC; end
      S_APP:  cmd_idx_o = IDX_APP;
      S_OP:   begin cmd_idx_o = IDX_OPC; cmd_arg_o = hc_q ? ARG_OPHC : ARG_OPSC; end
      default: begin cmd_req_o = 1'b0; cmd_resp_exp_o = 1'b0; end
    endcase
  end

  assign dly_en_o = (st_q == S_WAIT);
  assign done_o   = (st_q == S_DONE);
  assign err_o    = (st_q == S_ERR);
  assign hc_o     = hc_q;

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && !cmd_done_i) |=> (cmd_req_o && $stable(cmd_idx_o) && $stable(cmd_arg_o)));
  assert_rst_noresp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && cmd_idx_o == IDX_RST) |-> !cmd_resp_exp_o);
  assert_done_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cmd_done_i && cmd_idx_o == IDX_OPC && cmd_resp_i[31]));
  assert_done_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  assert_hc_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_OP || st_q == S_WAIT) |=> $stable(hc_o));
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq #(
  parameter int DLY_W   = 16,
  parameter int RETRY_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DLY_W-1:0]   delay_i,
  input  logic [RETRY_W-1:0] retry_max_i,
  output logic               cmd_req_o,
  output logic [5:0]         cmd_idx_o,
  output logic [31:0]        cmd_arg_o,
  output logic               cmd_resp_exp_o,
  input  logic               cmd_done_i,
  input  logic [1:0]         cmd_status_i,
  input  logic [31:0]        cmd_resp_i,
  output logic               done_o,
  output logic               err_o,
  output logic               hc_o
);
  logic dly_load, dly_en, dly_zero, pass_clr, pass_inc, pass_limit;
  logic dly_cfg_zero;

  assign dly_cfg_zero = (delay_i == '0);

  sd_init_fsm u_fsm (
    .clk_i, .rst_ni, .start_i,
    .dly_cfg_zero_i(dly_cfg_zero),
    .dly_zero_i    (dly_zero),
    .pass_limit_i  (pass_limit),
    .cmd_done_i, .cmd_status_i, .cmd_resp_i,
    .cmd_req_o, .cmd_idx_o, .cmd_arg_o, .cmd_resp_exp_o,
    .dly_load_o    (dly_load),
    .dly_en_o      (dly_en),
    .pass_clr_o    (pass_clr),
    .pass_inc_o    (pass_inc),
    .done_o, .err_o, .hc_o
  );

  sd_init_dly #(.DLY_W(DLY_W)) u_dly (
    .clk_i, .rst_ni,
    .load_i    (dly_load),
    .load_val_i(delay_i - 1'b1),
    .en_i      (dly_en),
    .zero_o    (dly_zero)
  );

  sd_init_pass #(.RETRY_W(RETRY_W)) u_pass (
    .clk_i, .rst_ni,
    .clr_i     (pass_clr),
    .inc_i     (pass_inc),
    .limit_i   (retry_max_i),
    .at_limit_o(pass_limit)
  );
endmodule

// File: tb/sim_sd_init_seq.sv
module sim_sd_init_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dly = '0;
  logic [11:0] rmax = 12'd1;
  logic        req, rexp, done, err, hc;
  logic [5:0]  idx;
  logic [31:0] arg;
  logic        cdone = 1'b0;
  logic [1:0]  cst = 2'b00;
  logic [31:0] cresp = '0;
  int          errs = 0;
  int          checks = 0;

  always #4 clk = ~clk;

  sd_init_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .delay_i(dly), .retry_max_i(rmax),
    .cmd_req_o(req), .cmd_idx_o(idx), .cmd_arg_o(arg), .cmd_resp_exp_o(rexp),
    .cmd_done_i(cdone), .cmd_status_i(cst), .cmd_resp_i(cresp),
    .done_o(done), .err_o(err), .hc_o(hc)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  task automatic get_req(output int gap);
    gap = 0;
    #1;
    while (!req && gap < 5000) begin
      gap++;
      @(negedge clk); #1;
    end
  endtask

  task automatic reply(input logic [1:0] s, input logic [31:0] r);
    logic [5:0]  i0;
    logic [31:0] a0;
    i0 = idx; a0 = arg;
    repeat ($urandom_range(0, 3)) @(negedge clk);
    #1;
    chk(req && idx == i0 && arg == a0, "R10 request held", {26'd0, idx}, {26'd0, i0});
    cdone = 1'b1; cst = s; cresp = r;
    @(negedge clk);
    cdone = 1'b0; cresp = $urandom();
    #1;
  endtask

  function automatic bit exp_hc(input logic [1:0] s, input logic [31:0] r);
    return (s == 2'b01) && (r[11:0] == 12'h1AA);
  endfunction

  // ends with done or err; checks every command against the requirement model
  task automatic run_case(input logic [1:0] s0, input logic [1:0] s8, input logic [31:0] r8,
                          input int ready, input int f55, input bit f55_bit, input int f41,
                          input int lim, input int d);
    int  g;
    bit  h;
    int  lim_eff;
    logic [31:0] r;
    lim_eff = (lim == 0) ? 1 : lim;
    rmax = lim[11:0]; dly = d[15:0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    get_req(g);
    chk(idx == 6'd0 && arg == 32'd0 && !rexp, "R2 reset command", {25'd0, rexp, idx}, 32'd0);
    // start while busy must not restart the sequence
    start = 1'b1;
    reply(s0, $urandom());
    start = 1'b0;
    if (s0 != 2'b00) begin
      chk(err && !done, "R2 reset status error", {30'd0, err, done}, 32'd2);
      return;
    end
    get_req(g);
    chk(idx == 6'd8 && arg == 32'h1AA && rexp, "R3 interface probe", arg, 32'h1AA);
    reply(s8, r8);
    h = exp_hc(s8, r8);
    for (int p = 1; p < 200; p++) begin
      get_req(g);
      chk(idx == 6'd55 && arg == 32'd0 && rexp, "R5 app command", {26'd0, idx}, 32'd55);
      chk(g == ((p == 1) ? 0 : d), "R8 inter-pass gap", g, (p == 1) ? 0 : d);
      if (p == f55) begin
        r = $urandom() | 32'h20;
        if (f55_bit) reply(2'b01, r & ~32'h20);
        else         reply(2'b10, r);
        chk(err && !done, "R5 app failure", {30'd0, err, done}, 32'd2);
        return;
      end
      reply(2'b01, $urandom() | 32'h20);
      get_req(g);
      chk(idx == 6'd41 && rexp && arg == (h ? 32'h40FF8000 : 32'h00800000), "R6 op argument",
          arg, h ? 32'h40FF8000 : 32'h00800000);
      if (p == f41) begin
        reply(2'b10, $urandom());
        chk(err && !done, "R6 op timeout", {30'd0, err, done}, 32'd2);
        return;
      end
      if (p >= ready) begin
        reply(2'b01, $urandom() | 32'h8000_0000);
        chk(done && !err, "R7 ready", {30'd0, done, err}, 32'd2);
        chk(hc == h, "R4 capacity flag", {31'd0, hc}, {31'd0, h});
        repeat (3) @(negedge clk);
        chk(!req && done, "R7 quiet after done", {30'd0, req, done}, 32'd1);
        return;
      end
      reply(2'b01, $urandom() & 32'h7FFF_FFFF);
      if (p >= lim_eff) begin
        chk(err && !done, "R9 retry limit", {30'd0, err, done}, 32'd2);
        return;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1207));
    #1;
    chk(!done && !err && !hc && !req, "R1 reset state", {28'd0, done, err, hc, req}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!done && !err && !hc && !req, "R1 idle after reset", {28'd0, done, err, hc, req}, 32'd0);
    run_case(2'b00, 2'b01, 32'h0000_01AA, 3, 0, 0, 0, 10, 2);   // high capacity
    run_case(2'b00, 2'b10, 32'h0000_01AA, 1, 0, 0, 0, 10, 0);   // probe timeout
    run_case(2'b00, 2'b01, 32'h0000_01AB, 2, 0, 0, 0, 10, 1);   // wrong echo
    run_case(2'b00, 2'b11, 32'h0000_01AA, 2, 0, 0, 0, 10, 3);   // probe fault
    run_case(2'b11, 2'b01, 32'h0000_01AA, 1, 0, 0, 0, 10, 0);   // reset fault
    run_case(2'b01, 2'b01, 32'h0000_01AA, 1, 0, 0, 0, 10, 0);   // reset got response
    run_case(2'b00, 2'b01, 32'hFFFF_F1AA, 4, 2, 1, 0, 10, 1);   // bit 5 low
    run_case(2'b00, 2'b10, 32'h0, 4, 1, 0, 0, 10, 1);           // app timeout
    run_case(2'b00, 2'b01, 32'h0000_01AA, 4, 0, 0, 2, 10, 0);   // op timeout
    run_case(2'b00, 2'b01, 32'h0000_01AA, 100, 0, 0, 0, 4, 2);  // never ready
    run_case(2'b00, 2'b10, 32'h0, 100, 0, 0, 0, 0, 1);          // zero limit
    run_case(2'b00, 2'b01, 32'h0000_01AA, 4, 0, 0, 0, 4, 0);    // ready on last pass
    for (int k = 0; k < 16; k++) begin
      logic [1:0]  s8r;
      logic [31:0] r8r;
      s8r = 2'($urandom_range(0, 3));
      r8r = ($urandom_range(0, 1) == 1) ? 32'h0000_01AA : $urandom();
      run_case(2'b00, s8r, r8r, $urandom_range(1, 6), 0, 0, 0,
               $urandom_range(0, 8), $urandom_range(0, 5));
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule